// File: doc/BRIEF.md
# APB Stalled-Transfer Terminator

This block watches the APB segment behind an AXI-to-APB bridge and guards it against slaves that never complete a transfer. It counts the clock cycles of every access phase that a slave spends with its ready signal low. When that count reaches a programmable limit, the block answers the bridge on the slave's behalf: it returns ready together with an error flag and all-zero read data, so the bus is released for the next access. At the same moment it captures the address of the stalled transfer and sets an interrupt-pending flag.

The block sits in the response path between the slave response multiplexer and the bridge. While no timeout occurs, the slave's response passes through unchanged. Accesses to address ranges where no slave exists get no ready from the multiplexer, so they also end through this timeout. A small APB register port exposes three 32-bit words at stride 4. The status word holds the pending flag and the interrupt enable. Software can set the pending flag on purpose to test the interrupt path. The captured address word is read-only. The limit word is clamped to a floor by the hardware.

Top module: `apb_tmo_guard`

## Requirements
- R1: After reset, the status word (offset 0x0) reads 0, the captured address word (offset 0x4) reads 0, the limit word (offset 0x8) reads 0x3FF, and irq_o is low.
- R2: In the status word, bit 0 is the pending flag and bit 1 is the interrupt enable. irq_o is high exactly when both are set.
- R3: A write to the status word loads the pending flag from write bit 0 (1 sets it, 0 clears it) and the enable from write bit 1. The register port completes every access in its first access cycle (cfg_pready_o high).
- R4: A write to the limit word stores the written value, or 0x3FF if the value is below 0x3FF. Every value from 0x3FF up to 0xFFFFFFFF is stored as written.
- R5: Suppose an access phase on the monitored bus sees no slave ready during its first LIMIT cycles and none in cycle LIMIT+1. The block then ends the transfer in cycle LIMIT+1 with brg_pready_o=1, brg_pslverr_o=1 and brg_prdata_o=0. On that same edge it stores the transfer address in the captured address word and sets the pending flag.
- R6: The stall count restarts at zero with every new access phase. A slave ready seen in any access cycle up to and including cycle LIMIT+1 completes the transfer normally, and no timeout is recorded.
- R7: When no timeout occurs, brg_pready_o, brg_pslverr_o and brg_prdata_o equal the slave's ready, error and read data.
- R8: If a timeout and a software write clearing the pending flag land on the same clock edge, the pending flag ends up set.
- R9: Writes to the captured address word have no effect. Any offset other than 0x0, 0x4 and 0x8 reads as 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | APB clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mon_psel_i | input | 1 | Select of the monitored APB transfer |
| mon_penable_i | input | 1 | Enable of the monitored APB transfer |
| mon_paddr_i | input | AW | Address of the monitored APB transfer |
| slv_pready_i | input | 1 | Ready from the slave response multiplexer |
| slv_pslverr_i | input | 1 | Error from the slave response multiplexer |
| slv_prdata_i | input | DW | Read data from the slave response multiplexer |
| brg_pready_o | output | 1 | Ready returned to the bridge |
| brg_pslverr_o | output | 1 | Error returned to the bridge |
| brg_prdata_o | output | DW | Read data returned to the bridge |
| cfg_psel_i | input | 1 | Register port select |
| cfg_penable_i | input | 1 | Register port enable |
| cfg_pwrite_i | input | 1 | Register port write strobe |
| cfg_paddr_i | input | 4 | Register port byte offset |
| cfg_pwdata_i | input | 32 | Register port write data |
| cfg_prdata_o | output | 32 | Register port read data |
| cfg_pready_o | output | 1 | Register port ready, always high |
| irq_o | output | 1 | Timeout interrupt, level high |

## Verification
The assertions assume that the monitored master follows the APB protocol. Every access phase is preceded by a setup cycle. Address and select stay stable until ready is returned, and the enable drops in the cycle after completion. They also assume that the limit word never holds zero, which the floor guarantees. The bench drives the monitored bus only through one transfer task that keeps to this protocol: a setup cycle, a held access phase, and release on the cycle after ready. The one same-edge collision it creates on purpose is a register write landing on the exact edge of a timeout.

// File: rtl/apb_tmo_pkg.sv
`timescale 1ns/1ps
package apb_tmo_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned REG_AW   = 4;
  localparam logic [REG_AW-1:0] OFS_STAT  = 4'h0;
  localparam logic [REG_AW-1:0] OFS_FADDR = 4'h4;
  localparam logic [REG_AW-1:0] OFS_LIMIT = 4'h8;
  localparam int unsigned STAT_PEND = 0;
  localparam int unsigned STAT_EN   = 1;

  typedef struct packed {
    logic en;
    logic pend;
  } stat_t;
endpackage

// File: rtl/apb_tmo_wdog.sv
`timescale 1ns/1ps
module apb_tmo_wdog
  import apb_tmo_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             slv_ready_i,
  input  logic [REG_W-1:0] limit_i,
  output logic             hit_o
);
  logic [REG_W-1:0] cnt_q;

  // slave ready wins over the limit in the same cycle
  assign hit_o = acc_i & ~slv_ready_i & (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!acc_i || slv_ready_i || hit_o) cnt_q <= '0;
    else                                  cnt_q <= cnt_q + REG_W'(1);
  end

  p_cnt_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(acc_i) |-> cnt_q == '0);

  p_hit_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && limit_i != '0) |=> !hit_o);
endmodule

// File: rtl/apb_tmo_regs.sv
`timescale 1ns/1ps
module apb_tmo_regs
  import apb_tmo_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter logic [31:0] TMO_MIN = 32'h0000_03FF,
  parameter logic [31:0] TMO_RST = 32'h0000_03FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_psel_i,
  input  logic              cfg_penable_i,
  input  logic              cfg_pwrite_i,
  input  logic [REG_AW-1:0] cfg_paddr_i,
  input  logic [REG_W-1:0]  cfg_pwdata_i,
  output logic [REG_W-1:0]  cfg_prdata_o,
  input  logic              hit_i,
  input  logic [AW-1:0]     fault_addr_i,
  output logic [REG_W-1:0]  limit_o,
  output stat_t             stat_o
);
  stat_t            stat_q;
  logic [REG_W-1:0] faddr_q, limit_q;
  logic             wr_en;

  assign wr_en = cfg_psel_i & cfg_penable_i & cfg_pwrite_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= '0;
      faddr_q <= '0;
      limit_q <= TMO_RST;
    end else begin
      if (wr_en && cfg_paddr_i == OFS_STAT) begin
        stat_q.pend <= cfg_pwdata_i[STAT_PEND];
        stat_q.en   <= cfg_pwdata_i[STAT_EN];
      end
      if (wr_en && cfg_paddr_i == OFS_LIMIT)
        limit_q <= (cfg_pwdata_i < TMO_MIN) ? TMO_MIN : cfg_pwdata_i;
      // hardware event placed last: it overrides a same-edge software clear
      if (hit_i) begin
        stat_q.pend <= 1'b1;
        faddr_q     <= REG_W'(fault_addr_i);
      end
    end
  end

  always_comb begin
    unique case (cfg_paddr_i)
      OFS_STAT:  cfg_prdata_o = REG_W'(stat_q);
      OFS_FADDR: cfg_prdata_o = faddr_q;
      OFS_LIMIT: cfg_prdata_o = limit_q;
      default:   cfg_prdata_o = '0;
    endcase
  end

  assign limit_o = limit_q;
  assign stat_o  = stat_q;

  p_hit_sets_pend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> stat_q.pend);

  p_addr_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> faddr_q == REG_W'($past(fault_addr_i)));

  p_limit_floor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    limit_q >= TMO_MIN);

  p_addr_ro_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && cfg_paddr_i == OFS_FADDR && !hit_i) |=> $stable(faddr_q));
endmodule

// File: rtl/apb_tmo_guard.sv
`timescale 1ns/1ps
module apb_tmo_guard
  import apb_tmo_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 32,
  parameter logic [31:0] TMO_MIN = 32'h0000_03FF,
  parameter logic [31:0] TMO_RST = 32'h0000_03FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mon_psel_i,
  input  logic              mon_penable_i,
  input  logic [AW-1:0]     mon_paddr_i,
  input  logic              slv_pready_i,
  input  logic              slv_pslverr_i,
  input  logic [DW-1:0]     slv_prdata_i,
  output logic              brg_pready_o,
  output logic              brg_pslverr_o,
  output logic [DW-1:0]     brg_prdata_o,
  input  logic              cfg_psel_i,
  input  logic              cfg_penable_i,
  input  logic              cfg_pwrite_i,
  input  logic [REG_AW-1:0] cfg_paddr_i,
  input  logic [REG_W-1:0]  cfg_pwdata_i,
  output logic [REG_W-1:0]  cfg_prdata_o,
  output logic              cfg_pready_o,
  output logic              irq_o
);
  logic             acc, hit;
  logic [REG_W-1:0] limit;
  stat_t            stat;

  assign acc = mon_psel_i & mon_penable_i;

  apb_tmo_wdog u_wdog (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (acc),
    .slv_ready_i (slv_pready_i),
    .limit_i     (limit),
    .hit_o       (hit)
  );

  apb_tmo_regs #(.AW(AW), .TMO_MIN(TMO_MIN), .TMO_RST(TMO_RST)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_psel_i    (cfg_psel_i),
    .cfg_penable_i (cfg_penable_i),
    .cfg_pwrite_i  (cfg_pwrite_i),
    .cfg_paddr_i   (cfg_paddr_i),
    .cfg_pwdata_i  (cfg_pwdata_i),
    .cfg_prdata_o  (cfg_prdata_o),
    .hit_i         (hit),
    .fault_addr_i  (mon_paddr_i),
    .limit_o       (limit),
    .stat_o        (stat)
  );

  // forced completion replaces the slave response for one cycle
  assign brg_pready_o  = slv_pready_i | hit;
  assign brg_pslverr_o = hit | slv_pslverr_i;
  assign brg_prdata_o  = hit ? '0 : slv_prdata_i;

  assign cfg_pready_o = 1'b1;
  assign irq_o        = stat.pend & stat.en;

  p_irq_needs_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> stat.en);

  p_term_releases_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !slv_pready_i && brg_pready_o) |-> (brg_pslverr_o && brg_prdata_o == '0));
endmodule

// File: tb/tb_apb_tmo_guard.sv
`timescale 1ns/1ps
module tb_apb_tmo_guard;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        m_psel = 0, m_pen = 0;
  logic [31:0] m_addr = '0;
  logic        s_rdy = 0, s_err = 0;
  logic [31:0] s_data = '0;
  logic        b_rdy, b_err;
  logic [31:0] b_data;
  logic        c_psel = 0, c_pen = 0, c_wr = 0;
  logic [3:0]  c_addr = '0;
  logic [31:0] c_wdata = '0, c_rdata;
  logic        c_rdy, irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  apb_tmo_guard dut (
    .clk_i(clk), .rst_ni(rst_n),
    .mon_psel_i(m_psel), .mon_penable_i(m_pen), .mon_paddr_i(m_addr),
    .slv_pready_i(s_rdy), .slv_pslverr_i(s_err), .slv_prdata_i(s_data),
    .brg_pready_o(b_rdy), .brg_pslverr_o(b_err), .brg_prdata_o(b_data),
    .cfg_psel_i(c_psel), .cfg_penable_i(c_pen), .cfg_pwrite_i(c_wr),
    .cfg_paddr_i(c_addr), .cfg_pwdata_i(c_wdata), .cfg_prdata_o(c_rdata),
    .cfg_pready_o(c_rdy), .irq_o(irq)
  );

  // {write value, expected read-back} for the limit word
  localparam logic [63:0] LIM_VEC [7] = '{
    {32'h0000_0000, 32'h0000_03FF}, {32'h0000_0001, 32'h0000_03FF},
    {32'h0000_03FE, 32'h0000_03FF}, {32'h0000_03FF, 32'h0000_03FF},
    {32'h0000_0400, 32'h0000_0400}, {32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'h0000_0500, 32'h0000_0500}};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cfg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); c_psel = 1; c_pen = 0; c_wr = 1; c_addr = a; c_wdata = d;
    @(negedge clk); c_pen = 1;
    @(negedge clk); c_psel = 0; c_pen = 0; c_wr = 0;
  endtask

  task automatic cfg_rd(input logic [3:0] a, output logic [31:0] d, output logic rdy);
    @(negedge clk); c_psel = 1; c_pen = 0; c_wr = 0; c_addr = a;
    @(negedge clk); c_pen = 1; #1 d = c_rdata; rdy = c_rdy;
    @(negedge clk); c_psel = 0; c_pen = 0;
  endtask

  // rdy_at: access cycle with slave ready (0 = never); clr_at: cycle of a same-edge status write of 0x2
  task automatic mon_xfer(input logic [31:0] a, input int rdy_at, input int clr_at,
                          output int done_at, output logic err, output logic [31:0] data);
    done_at = 0; err = 0; data = '0;
    @(negedge clk); m_psel = 1; m_pen = 0; m_addr = a; s_rdy = 0;
    @(negedge clk); m_pen = 1;
    for (int i = 1; i <= 5000 && done_at == 0; i++) begin
      if (i > 1) @(negedge clk);
      s_rdy = (i == rdy_at);
      if (clr_at != 0) begin
        if (i == clr_at - 1) begin c_psel = 1; c_pen = 0; c_wr = 1; c_addr = 4'h0; c_wdata = 32'h2; end
        else if (i == clr_at) c_pen = 1;
      end
      #1;
      if (b_rdy) begin done_at = i; err = b_err; data = b_data; end
    end
    @(negedge clk); m_psel = 0; m_pen = 0; s_rdy = 0; c_psel = 0; c_pen = 0; c_wr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, dat;
    logic r, e;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1 chk("R1 irq after reset", {31'b0, irq}, 0);
    cfg_rd(4'h0, d, r); chk("R1 status reset", d, 0);
    chk("R3 cfg ready", {31'b0, r}, 1);
    cfg_rd(4'h4, d, r); chk("R1 address reset", d, 0);
    cfg_rd(4'h8, d, r); chk("R1 limit reset", d, 32'h3FF);

    for (int i = 0; i < 7; i++) begin
      cfg_wr(4'h8, LIM_VEC[i][63:32]);
      cfg_rd(4'h8, d, r); chk("R4 limit clamp", d, LIM_VEC[i][31:0]);
    end
    cfg_wr(4'h8, 32'h3FF);

    s_data = 32'hA5A5_5A5A; s_err = 0;
    mon_xfer(32'h0800_0010, 3, 0, n, e, dat);
    chk("R7 pass cycle", n, 3); chk("R7 pass err", {31'b0, e}, 0); chk("R7 pass data", dat, 32'hA5A5_5A5A);
    s_err = 1;
    mon_xfer(32'h0800_0020, 1, 0, n, e, dat);
    chk("R7 pass cycle err", n, 1); chk("R7 slave err", {31'b0, e}, 1);
    s_err = 0;

    mon_xfer(32'h0800_0030, 32'h400, 0, n, e, dat);
    chk("R6 boundary slave wins", n, 32'h400); chk("R6 boundary err", {31'b0, e}, 0);
    chk("R6 boundary data", dat, 32'hA5A5_5A5A);
    mon_xfer(32'h0800_0040, 32'h3FF, 0, n, e, dat); chk("R6 first long", n, 32'h3FF);
    mon_xfer(32'h0800_0044, 32'h3FF, 0, n, e, dat); chk("R6 second long", n, 32'h3FF);
    cfg_rd(4'h0, d, r); chk("R6 no pending", d, 0);

    mon_xfer(32'h1D00_0040, 0, 0, n, e, dat);
    chk("R5 term cycle", n, 32'h400); chk("R5 term err", {31'b0, e}, 1); chk("R5 term data", dat, 0);
    cfg_rd(4'h0, d, r); chk("R5 pending set", d, 32'h1);
    cfg_rd(4'h4, d, r); chk("R5 address", d, 32'h1D00_0040);
    chk("R2 masked irq", {31'b0, irq}, 0);

    cfg_wr(4'h0, 32'h2); cfg_rd(4'h0, d, r); chk("R3 clear pend set en", d, 32'h2);
    chk("R2 irq no pend", {31'b0, irq}, 0);
    cfg_wr(4'h0, 32'h3); cfg_rd(4'h0, d, r); chk("R3 sw set", d, 32'h3);
    chk("R2 irq both", {31'b0, irq}, 1);
    cfg_wr(4'h0, 32'h1); chk("R2 irq en off", {31'b0, irq}, 0);
    cfg_wr(4'h0, 32'h2); chk("R3 irq cleared", {31'b0, irq}, 0);

    cfg_wr(4'h4, 32'h0000_FFFF); cfg_rd(4'h4, d, r); chk("R9 address read-only", d, 32'h1D00_0040);
    cfg_wr(4'hC, 32'hFFFF_FFFF); cfg_rd(4'hC, d, r); chk("R9 hole reads zero", d, 0);
    cfg_rd(4'h0, d, r); chk("R9 status untouched", d, 32'h2);
    cfg_rd(4'h8, d, r); chk("R9 limit untouched", d, 32'h3FF);

    cfg_wr(4'h8, 32'h400);
    mon_xfer(32'h1FFF_FFFC, 0, 0, n, e, dat);
    chk("R5 new limit cycle", n, 32'h401);
    chk("R2 irq on timeout", {31'b0, irq}, 1);
    cfg_rd(4'h4, d, r); chk("R5 address 2", d, 32'h1FFF_FFFC);

    mon_xfer(32'h1E00_0000, 0, 32'h401, n, e, dat);
    chk("R8 term cycle", n, 32'h401);
    cfg_rd(4'h0, d, r); chk("R8 hw over sw", d, 32'h3);
    cfg_rd(4'h4, d, r); chk("R8 address", d, 32'h1E00_0000);
    cfg_wr(4'h0, 32'h2); cfg_rd(4'h0, d, r); chk("R3 clear after", d, 32'h2);
    chk("R3 irq low", {31'b0, irq}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule